// File: doc/BRIEF.md
# SPI Master Serial-Clock and Lead-Delay Timer

This block times one frame of an SPI master. A start request raises the chip-select enable. The block then waits a programmable lead interval, and after that it produces a fixed number of serial-clock transitions. Each transition is a one-cycle strobe: either a leading edge (SCK leaves idle) or a trailing edge (SCK returns to idle). A shifter or pin driver next to the block uses the strobes to move data and to toggle the SCK pin. The block does not shift data, and it has no trailing or inter-frame delays.

The SCK period comes from a prescaler code, a scaler code and a rate-doubling bit. The lead interval comes from its own separate prescaler and scaler codes. The block captures all codes when it accepts a start, so they stay fixed for the whole frame. The start, code and status pins are plain levels and strobes. There is no handshake: start is only taken while the block is idle, and at any other time it is ignored.

Top module: `sck_lead_timer`

## Requirements
- R1: During reset and after reset, before any start, cs_en, busy, sck_lead and sck_trail are all 0.
- R2: When start is high at a clock edge while busy is 0, cs_en and busy are 1 after that edge. A start that arrives while busy is 1 has no effect: no second frame follows.
- R3: The first strobe is always sck_lead. It appears exactly Pl*Sl clocks after the edge that raised cs_en. Pl is the lead prescaler factor, and lead_pre codes 0,1,2,3 select 2,3,5,7.
- R4: Both scaler fields decode the same way. Codes 0 to 3 select 2, 4, 6 and 8. A code c from 4 to 15 selects 2^(c+1), which covers 32 up to 65536.
- R5: With dbl_rate 0, the SCK period is Pb*Sb clocks, where Pb uses the same 2/3/5/7 prescaler map. A sck_lead is followed by sck_trail after half the period, and sck_trail is followed by the next sck_lead after the other half.
- R6: With dbl_rate 1, the period is Pb*Sb/2 clocks. If that count is odd, the high phase (from sck_lead to sck_trail) is one clock longer than the low phase.
- R7: A frame carries exactly 2*FRAME_BITS strobes. They alternate sck_lead and sck_trail, beginning with sck_lead, and the two strobes are never high together or outside cs_en.
- R8: cs_en and busy fall one clock after the final sck_trail strobe.
- R9: Changes to any code input while busy is 1 do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Protocol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request, taken only while idle |
| baud_pre | input | 2 | SCK prescaler code |
| baud_scl | input | 4 | SCK scaler code |
| dbl_rate | input | 1 | Halves the scaler division |
| lead_pre | input | 2 | Lead-delay prescaler code |
| lead_scl | input | 4 | Lead-delay scaler code |
| cs_en | output | 1 | Chip-select enable for the frame |
| busy | output | 1 | Frame in progress |
| sck_lead | output | 1 | One-cycle strobe: SCK leaves idle |
| sck_trail | output | 1 | One-cycle strobe: SCK returns to idle |

## Verification
All results are measured in clocks from the edge that accepted start. cs_en and busy are due one clock later (offset 0). The first sck_lead is due at offset Pl*Sl. Each later strobe is due a half period after the one before it. cs_en is due to fall one clock after the last strobe. The bench drives inputs and samples outputs on falling edges and counts offsets from that accepting edge. It records the offset of every strobe and compares the whole list with a schedule computed from the code maps. One frame changes the codes and pulses start partway through, and it is held to the schedule of the codes captured at acceptance.

// File: rtl/sck_timing_pkg.sv
package sck_timing_pkg;
  localparam int PRE_W = 2;
  localparam int SCL_W = 4;
  localparam int FAC_W = 17;
  localparam int CNT_W = 20;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SCK, ST_DONE} seq_state_t;

  function automatic logic [2:0] pre_factor(input logic [PRE_W-1:0] code);
    case (code)
      2'd0:    pre_factor = 3'd2;
      2'd1:    pre_factor = 3'd3;
      2'd2:    pre_factor = 3'd5;
      default: pre_factor = 3'd7;
    endcase
  endfunction

  function automatic logic [FAC_W-1:0] scl_factor(input logic [SCL_W-1:0] code);
    case (code)
      4'd0:    scl_factor = FAC_W'(2);
      4'd1:    scl_factor = FAC_W'(4);
      4'd2:    scl_factor = FAC_W'(6);
      4'd3:    scl_factor = FAC_W'(8);
      default: scl_factor = FAC_W'(1) << ({1'b0, code} + 5'd1);
    endcase
  endfunction
endpackage

// File: rtl/sck_code_decode.sv
module sck_code_decode
  import sck_timing_pkg::*;
(
  input  logic [PRE_W-1:0] pre_code,
  input  logic [SCL_W-1:0] scl_code,
  output logic [CNT_W-1:0] clocks
);
  logic [2:0]       pre_f;
  logic [FAC_W-1:0] scl_f;

  always_comb begin
    pre_f  = pre_factor(pre_code);
    scl_f  = scl_factor(scl_code);
    clocks = CNT_W'(pre_f) * CNT_W'(scl_f);
  end
endmodule

// File: rtl/sck_phase_calc.sv
module sck_phase_calc
  import sck_timing_pkg::*;
(
  input  logic [CNT_W-1:0] full_div,
  input  logic             dbl,
  output logic [CNT_W-1:0] high_len,
  output logic [CNT_W-1:0] low_len
);
  logic [CNT_W-1:0] period;

  always_comb begin
    period   = dbl ? (full_div >> 1) : full_div;
    high_len = (period + CNT_W'(1)) >> 1;
    low_len  = period >> 1;
  end
endmodule

// File: rtl/sck_edge_seq.sv
module sck_edge_seq
  import sck_timing_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] lead_len,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] low_len,
  output logic             cs_en,
  output logic             busy,
  output logic             sck_lead,
  output logic             sck_trail
);
  localparam int EDGES  = 2 * FRAME_BITS;
  localparam int EDGE_W = $clog2(EDGES + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [EDGE_W-1:0] ecnt;

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      ecnt      <= '0;
      cs_en     <= 1'b0;
      sck_lead  <= 1'b0;
      sck_trail <= 1'b0;
    end else begin
      sck_lead  <= 1'b0;
      sck_trail <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_LEAD;
            cs_en <= 1'b1;
            cnt   <= lead_len - CNT_W'(1);
            ecnt  <= '0;
          end
        end
        ST_LEAD: begin
          if (cnt == '0) begin
            sck_lead <= 1'b1;
            ecnt     <= EDGE_W'(1);
            cnt      <= high_len - CNT_W'(1);
            state    <= ST_SCK;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_SCK: begin
          if (cnt == '0) begin
            if (ecnt[0]) begin
              sck_trail <= 1'b1;
              cnt       <= low_len - CNT_W'(1);
            end else begin
              sck_lead <= 1'b1;
              cnt      <= high_len - CNT_W'(1);
            end
            ecnt <= ecnt + EDGE_W'(1);
            if (ecnt == EDGE_W'(EDGES - 1)) state <= ST_DONE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          cs_en <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_lead && sck_trail)); // R7
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_lead || sck_trail) |-> cs_en); // R7
  AST_CS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (cs_en && busy)); // R2
  AST_NO_EARLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_en) |-> !(sck_lead || sck_trail)); // R3
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (!cs_en && !busy)); // R8
endmodule

// File: rtl/sck_lead_timer.sv
module sck_lead_timer
  import sck_timing_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] baud_pre,
  input  logic [3:0] baud_scl,
  input  logic       dbl_rate,
  input  logic [1:0] lead_pre,
  input  logic [3:0] lead_scl,
  output logic       cs_en,
  output logic       busy,
  output logic       sck_lead,
  output logic       sck_trail
);
  logic [PRE_W-1:0] bpre_q;
  logic [SCL_W-1:0] bscl_q;
  logic             dbl_q;
  logic [CNT_W-1:0] lead_len, baud_full, high_len, low_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bpre_q <= '0;
      bscl_q <= '0;
      dbl_q  <= 1'b0;
    end else if (start && !busy) begin
      bpre_q <= baud_pre;
      bscl_q <= baud_scl;
      dbl_q  <= dbl_rate;
    end
  end

  sck_code_decode u_lead_dec (
    .pre_code (lead_pre),
    .scl_code (lead_scl),
    .clocks   (lead_len)
  );

  sck_code_decode u_baud_dec (
    .pre_code (bpre_q),
    .scl_code (bscl_q),
    .clocks   (baud_full)
  );

  sck_phase_calc u_phase (
    .full_div (baud_full),
    .dbl      (dbl_q),
    .high_len (high_len),
    .low_len  (low_len)
  );

  sck_edge_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lead_len  (lead_len),
    .high_len  (high_len),
    .low_len   (low_len),
    .cs_en     (cs_en),
    .busy      (busy),
    .sck_lead  (sck_lead),
    .sck_trail (sck_trail)
  );

  AST_CODES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bpre_q) && $stable(bscl_q) && $stable(dbl_q))); // R9
endmodule

// File: tb/sim_sck_lead_timer.sv
module sim_sck_lead_timer;
  localparam int NBITS = 8;
  localparam int NEDGE = 2 * NBITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] baud_pre = '0;
  logic [3:0] baud_scl = '0;
  logic dbl_rate = 1'b0;
  logic [1:0] lead_pre = '0;
  logic [3:0] lead_scl = '0;
  logic cs_en, busy, sck_lead, sck_trail;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sck_lead_timer #(.FRAME_BITS(NBITS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .baud_pre(baud_pre), .baud_scl(baud_scl), .dbl_rate(dbl_rate),
    .lead_pre(lead_pre), .lead_scl(lead_scl),
    .cs_en(cs_en), .busy(busy), .sck_lead(sck_lead), .sck_trail(sck_trail)
  );

  function automatic int pre_v(input int c);
    case (c)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic int scl_v(input int c);
    if (c < 4) return 2 * (c + 1);
    return 1 << (c + 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!cs_en && !busy && !sck_lead && !sck_trail, "R1", "outputs in reset",
          {cs_en, busy, sck_lead, sck_trail}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!cs_en && !busy && !sck_lead && !sck_trail, "R1", "outputs idle after reset",
          {cs_en, busy, sck_lead, sck_trail}, 0);
  endtask

  task automatic run_frame(input int bp, input int bs, input int dr,
                           input int lp, input int ls, input bit disturb,
                           input string lead_req, input string per_req);
    int times[NEDGE + 4];
    bit kinds[NEDGE + 4];
    int ns = 0;
    int k = 0;
    int endk = -1;
    bit both = 1'b0;
    int exp_l, full, per, hi, lo, exp_t, bad_at, bad_act, bad_exp;
    bit order_ok;
    exp_l = pre_v(lp) * scl_v(ls);
    full  = pre_v(bp) * scl_v(bs);
    per   = (dr != 0) ? full / 2 : full;
    hi    = (per + 1) / 2;
    lo    = per / 2;

    @(negedge clk);
    baud_pre = bp[1:0]; baud_scl = bs[3:0]; dbl_rate = dr[0];
    lead_pre = lp[1:0]; lead_scl = ls[3:0];
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(cs_en && busy && !sck_lead && !sck_trail, "R2", "cs_en/busy one clock after start",
          {cs_en, busy, sck_lead, sck_trail}, 4'b1100);
    while (k < 40000) begin
      if (k > 0 && !cs_en) begin
        endk = k;
        break;
      end
      if (sck_lead && sck_trail) both = 1'b1;
      if ((sck_lead || sck_trail) && ns < NEDGE + 4) begin
        times[ns] = k;
        kinds[ns] = sck_lead;
        ns++;
      end
      if (disturb && k == 10) begin
        start = 1'b1; baud_pre = 2'd3; baud_scl = 4'd6; dbl_rate = ~dbl_rate;
        lead_pre = 2'd3; lead_scl = 4'd5;
      end
      if (disturb && k == 11) start = 1'b0;
      @(negedge clk);
      k++;
    end

    check(ns > 0 && times[0] == exp_l, lead_req, "lead delay to first strobe",
          (ns > 0) ? times[0] : -1, exp_l);

    bad_at = -1; bad_act = 0; bad_exp = 0;
    exp_t = exp_l;
    for (int i = 0; i < NEDGE && i < ns; i++) begin
      if (times[i] != exp_t && bad_at < 0) begin
        bad_at = i; bad_act = times[i]; bad_exp = exp_t;
      end
      exp_t = exp_t + (((i % 2) == 0) ? hi : lo);
    end
    check(bad_at < 0, per_req, "strobe schedule", bad_act, bad_exp);

    order_ok = (ns == NEDGE) && !both;
    for (int i = 0; i < NEDGE && i < ns; i++)
      if (kinds[i] != ((i % 2) == 0)) order_ok = 1'b0;
    check(order_ok, "R7", "strobe count and lead/trail order", ns, NEDGE);

    check(ns > 0 && endk == times[ns - 1] + 1 && !busy, "R8", "cs_en/busy fall after last strobe",
          endk, (ns > 0) ? times[ns - 1] + 1 : -1);

    if (disturb) begin
      repeat (6) @(negedge clk);
      check(!cs_en && !busy, "R2", "start while busy ignored, no second frame",
            {cs_en, busy}, 0);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    // R5 with R3: 100 MHz example codes, period 4, lead 3*32 = 96
    run_frame(0, 0, 0, 1, 4, 1'b0, "R3", "R5");
    // R6: doubled rate, period 2
    run_frame(0, 0, 1, 0, 0, 1'b0, "R3", "R6");
    // R6: odd period 3 -> high 2, low 1; lead 5*4
    run_frame(1, 0, 1, 2, 1, 1'b0, "R3", "R6");
    // R5 with prescaler 7 and scaler code 3 (8); lead 7*2
    run_frame(3, 3, 0, 3, 0, 1'b0, "R3", "R5");
    // R4: scaler code 5 (64) with prescaler 5; lead scaler code 2 (6)
    run_frame(2, 5, 0, 0, 2, 1'b0, "R4", "R4");
    // R9: codes changed and start pulsed mid-frame
    run_frame(0, 1, 1, 0, 3, 1'b1, "R3", "R9");
    summary();
  end
endmodule